// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block chooses which exception a processor core services next. It tracks six maskable peripheral sources (external request pin, timer channel 0, timer channel 1, timer overflow, keyboard, ADC conversion complete) and one software-interrupt request. Each maskable source has its own pending flag with set and clear inputs, and its own enable. A global mask input blocks every maskable source but never the software interrupt. Reset is the highest-priority exception and is handled by the asynchronous reset itself.

The core raises `boundary_strobe` at an instruction boundary. In that cycle the block picks the highest-priority eligible source and offers it. It drives `int_req` together with the source number, the 16-bit vector address and a return-address select. The offer holds still until the core answers with `cpu_ack`. The pending flags are also exposed as fixed bits of a 16-bit status word.

The control is a three-state machine. `ST_BOOT` is held while reset is asserted. On the first clock after reset it takes the transition *boot_done* to `ST_IDLE`. In `ST_IDLE`, a strobe that finds an eligible source takes *grant* to `ST_OFFER` and captures the winner. A strobe that finds none stays in `ST_IDLE` (*no_winner*). `ST_OFFER` returns to `ST_IDLE` on *acked* when `cpu_ack` is high, and otherwise stays (*hold*).

Top module: `irq_vector_arb`

## Requirements
- R1: At a strobe, the winner is the eligible source with the lowest source number. The numbering runs 0 reset, 1 software interrupt, 2 request pin, 3 timer channel 0, 4 timer channel 1, 5 timer overflow, 6 keyboard, 7 ADC. This number is driven on `src_id` while `int_req` is high.
- R2: While `int_req` is high, `vec_addr` gives the vector for `src_id`: 0→FFFE, 1→FFFC, 2→FFFA, 3→FFF6, 4→FFF4, 5→FFF2, 6→FFE0, 7→FFDE (hex).
- R3: With `i_mask` high, no maskable source can win. A software interrupt (`swi_req` high at the strobe) is still granted whatever the state of `i_mask`.
- R4: While `int_req` is high, `stack_pc` is 1 (stack PC) for the software interrupt and 0 (stack PC-1) for every hardware source.
- R5: Maskable source k (bit k of `src_set`/`src_clr`/`src_en`: 0 pin, 1 ch0, 2 ch1, 3 overflow, 4 keyboard, 5 ADC) is eligible only when its flag is set and `src_en[k]` is high.
- R6: `isr_status` bit 1 shows the pin flag, bit 3 ch0, bit 4 ch1, bit 5 overflow, bit 14 keyboard and bit 15 ADC, regardless of enables. All other bits read 0.
- R7: While `rst_n` is low, `int_req` is 0, `vec_addr` is FFFE, `src_id` is 0 and all flags are cleared, even with set inputs high.
- R8: Arbitration happens only on a strobe in `ST_IDLE`. `int_req` rises one cycle after that strobe. The offered `src_id` and `vec_addr` stay unchanged, and further strobes are ignored, until `cpu_ack`. The cycle after `cpu_ack`, `int_req` is 0.
- R9: `cpu_ack` does not clear a flag, so a source still pending and enabled wins again at the next strobe.
- R10: A flag becomes 1 the cycle after its set input is high. It becomes 0 the cycle after its clear input is high without its set input. When both are high, set wins.
- R11: A strobe with no eligible source leaves `int_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 6 | Per-source flag set pulses |
| src_clr | input | 6 | Per-source flag clear pulses |
| src_en | input | 6 | Per-source local enables |
| i_mask | input | 1 | Global mask for maskable sources |
| swi_req | input | 1 | Software interrupt request, sampled at strobe |
| boundary_strobe | input | 1 | Instruction boundary, arbitration point |
| cpu_ack | input | 1 | Core accepts the offered vector |
| int_req | output | 1 | An exception is being offered |
| vec_addr | output | 16 | Vector address of the offered source |
| src_id | output | 3 | Number of the offered source |
| stack_pc | output | 1 | 1: stack PC, 0: stack PC-1 |
| isr_status | output | 16 | Pending flag status word |

## Verification
The most important collision is between the global mask and the software interrupt when both are present at the same strobe. The sweep drives every combination of software request, mask, six flags and six enables. It checks that a masked bank still yields the software vector with `stack_pc` at 1. A second collision is a new, higher-priority request arriving while an offer is held. The bench raises one together with a strobe during `ST_OFFER` and checks that the held vector is unchanged until the acknowledge. The same check confirms that the new request wins at the following strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int NUM_SRC  = 8;
    localparam int NUM_MSK  = 6;
    localparam int MSK_BASE = 2;
    localparam int ID_W     = $clog2(NUM_SRC);
    localparam int VEC_W    = 16;
    localparam int STAT_W   = 16;

    typedef enum logic [ID_W-1:0] {
        SRC_RST  = 3'd0,
        SRC_SWI  = 3'd1,
        SRC_PIN  = 3'd2,
        SRC_TCH0 = 3'd3,
        SRC_TCH1 = 3'd4,
        SRC_TOVF = 3'd5,
        SRC_KBD  = 3'd6,
        SRC_ADC  = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_OFFER = 2'd2
    } arb_state_e;

    function automatic logic [VEC_W-1:0] vector_of(input logic [ID_W-1:0] id);
        logic [VEC_W-1:0] v;
        unique case (id)
            SRC_RST:  v = 16'hFFFE;
            SRC_SWI:  v = 16'hFFFC;
            SRC_PIN:  v = 16'hFFFA;
            SRC_TCH0: v = 16'hFFF6;
            SRC_TCH1: v = 16'hFFF4;
            SRC_TOVF: v = 16'hFFF2;
            SRC_KBD:  v = 16'hFFE0;
            default:  v = 16'hFFDE;
        endcase
        return v;
    endfunction

    // Status-word bit for maskable source index m (decoded by software).
    function automatic int status_pos(input int m);
        int p;
        case (m)
            0:       p = 1;
            1:       p = 3;
            2:       p = 4;
            3:       p = 5;
            4:       p = 14;
            default: p = 15;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_arb_pkg::*;
#(
    parameter int N = NUM_MSK,
    parameter int W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o,
    output logic [W-1:0] status_o
);

    logic [N-1:0] flag_q;

    for (genvar k = 0; k < N; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                flag_q[k] <= 1'b1;
            end else if (clr_i[k]) begin
                flag_q[k] <= 1'b0;
            end
        end

        // R10: a set pulse is seen in the flag one cycle later
        p_set_lands_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_o[k]);
        // R10: a lone clear pulse empties the flag one cycle later
        p_clr_lands_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
    end

    always_comb begin
        status_o = '0;
        for (int m = 0; m < N; m++) begin
            status_o[status_pos(m)] = flag_q[m];
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           found_o,
    output logic [IDW-1:0] idx_o
);

    // Lowest index wins: scan downward so the last hit is the smallest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MSK-1:0] src_set,
    input  logic [NUM_MSK-1:0] src_clr,
    input  logic [NUM_MSK-1:0] src_en,
    input  logic              i_mask,
    input  logic              swi_req,
    input  logic              boundary_strobe,
    input  logic              cpu_ack,
    output logic              int_req,
    output logic [VEC_W-1:0]  vec_addr,
    output logic [ID_W-1:0]   src_id,
    output logic              stack_pc,
    output logic [STAT_W-1:0] isr_status
);

    logic [NUM_MSK-1:0] flag;
    logic [NUM_SRC-1:0] elig;
    logic               win_found;
    logic [ID_W-1:0]    win_idx;
    arb_state_e         state;
    logic [ID_W-1:0]    held_id;

    irq_flag_bank #(.N(NUM_MSK), .W(STAT_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (src_set),
        .clr_i    (src_clr),
        .flag_o   (flag),
        .status_o (isr_status)
    );

    // Eligibility: reset is never requestable here, SWI ignores the mask.
    assign elig[SRC_RST] = 1'b0;
    assign elig[SRC_SWI] = swi_req;
    for (genvar m = 0; m < NUM_MSK; m++) begin : g_elig
        assign elig[MSK_BASE+m] = flag[m] & src_en[m] & ~i_mask;
    end

    irq_prio_pick #(.N(NUM_SRC), .IDW(ID_W)) u_pick (
        .req_i   (elig),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    // State register and captured winner.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_BOOT;
            held_id <= SRC_RST;
        end else begin
            unique case (state)
                ST_BOOT: state <= ST_IDLE;                      // boot_done
                ST_IDLE: begin
                    if (boundary_strobe && win_found) begin     // grant
                        state   <= ST_OFFER;
                        held_id <= win_idx;
                    end
                end
                ST_OFFER: begin
                    if (cpu_ack) state <= ST_IDLE;              // acked
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs from state.
    always_comb begin
        int_req  = 1'b0;
        vec_addr = vector_of(SRC_RST);
        src_id   = SRC_RST;
        stack_pc = 1'b0;
        unique case (state)
            ST_BOOT, ST_IDLE: ;
            ST_OFFER: begin
                int_req  = 1'b1;
                vec_addr = vector_of(held_id);
                src_id   = held_id;
                stack_pc = (held_id == SRC_SWI);
            end
            default: ;
        endcase
    end

    // R8: an offer only appears after a strobe
    p_offer_after_strobe_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> $past(boundary_strobe));
    // R8: unacknowledged offer stays fixed
    p_offer_stable_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !cpu_ack) |=> (int_req && $stable(vec_addr) && $stable(src_id)));
    // R3: under the global mask only the software interrupt can be granted
    p_mask_blocks_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_req) && $past(i_mask)) |-> (src_id == SRC_SWI));
    // R4: return-address select follows the software vector
    p_stack_sel_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (stack_pc == (vec_addr == 16'hFFFC)));
    // R8: acknowledge ends the offer
    p_ack_ends_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && cpu_ack) |=> !int_req);

endmodule

// File: tb/test_irq_vector_arb.sv
module test_irq_vector_arb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  src_set, src_clr, src_en;
    logic        i_mask, swi_req, boundary_strobe, cpu_ack;
    logic        int_req;
    logic [15:0] vec_addr;
    logic [2:0]  src_id;
    logic        stack_pc;
    logic [15:0] isr_status;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_vector_arb i_irq_vector_arb (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .src_en(src_en), .i_mask(i_mask), .swi_req(swi_req),
        .boundary_strobe(boundary_strobe), .cpu_ack(cpu_ack),
        .int_req(int_req), .vec_addr(vec_addr), .src_id(src_id),
        .stack_pc(stack_pc), .isr_status(isr_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_vec(input int id);
        case (id)
            0: return 16'hFFFE;
            1: return 16'hFFFC;
            2: return 16'hFFFA;
            3: return 16'hFFF6;
            4: return 16'hFFF4;
            5: return 16'hFFF2;
            6: return 16'hFFE0;
            default: return 16'hFFDE;
        endcase
    endfunction

    function automatic logic [15:0] ref_stat(input logic [5:0] f);
        logic [15:0] s = '0;
        s[1] = f[0]; s[3] = f[1]; s[4] = f[2];
        s[5] = f[3]; s[14] = f[4]; s[15] = f[5];
        return s;
    endfunction

    // Returns -1 when nothing is eligible.
    function automatic int ref_win(input logic s, input logic im, input logic [5:0] f, input logic [5:0] e);
        if (s) return 1;
        if (!im) for (int k = 0; k < 6; k++) if (f[k] && e[k]) return k + 2;
        return -1;
    endfunction

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic strobe_expect(input int exp_id, input string tag);
        @(negedge clk) boundary_strobe = 1'b1;
        @(negedge clk) boundary_strobe = 1'b0;
        chk({tag, " int_req"}, int_req, exp_id >= 0);
        if (exp_id >= 0) begin
            chk({tag, " src_id"}, src_id, exp_id);
            chk({tag, " vec_addr"}, vec_addr, ref_vec(exp_id));
        end
    endtask

    task automatic ack_once;
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) cpu_ack = 1'b0;
        chk("R8 idle after ack", int_req, 1'b0);
    endtask

    task automatic run_combo(input logic s, input logic im, input logic [5:0] f, input logic [5:0] e);
        int w;
        @(negedge clk);
        src_en = e; i_mask = im; swi_req = s;
        src_set = f; src_clr = 6'h3F; boundary_strobe = 1'b0; cpu_ack = 1'b0;
        @(negedge clk);
        src_set = '0; src_clr = '0;
        chk("R6 R10 status", isr_status, ref_stat(f));
        boundary_strobe = 1'b1;
        @(negedge clk);
        boundary_strobe = 1'b0;
        w = ref_win(s, im, f, e);
        chk("R1 R3 R5 R11 int_req", int_req, w >= 0);
        if (w >= 0) begin
            chk("R1 R3 R5 src_id", src_id, w);
            chk("R2 vec_addr", vec_addr, ref_vec(w));
            chk("R4 stack_pc", stack_pc, w == 1);
            cpu_ack = 1'b1;
        end
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R8 idle after ack", int_req, 1'b0);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        src_set = 6'h3F; src_clr = '0; src_en = 6'h3F;
        i_mask = 1'b0; swi_req = 1'b1; boundary_strobe = 1'b1; cpu_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset int_req", int_req, 1'b0);
        chk("R7 reset vec_addr", vec_addr, 16'hFFFE);
        chk("R7 reset src_id", src_id, 0);
        chk("R7 reset status", isr_status, 16'h0000);
        src_set = '0; swi_req = 1'b0; boundary_strobe = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Exhaustive sweep.
        for (int s = 0; s < 2; s++)
            for (int im = 0; im < 2; im++)
                for (int f = 0; f < 64; f++)
                    for (int e = 0; e < 64; e++)
                        run_combo(s[0], im[0], f[5:0], e[5:0]);

        // R8: hold while a higher source and a new strobe arrive.
        @(negedge clk);
        src_clr = 6'h3F; src_en = 6'h3F; i_mask = 1'b0; swi_req = 1'b0;
        @(negedge clk);
        src_clr = '0; src_set = 6'b100000;
        @(negedge clk) src_set = '0;
        strobe_expect(7, "R8 adc offer");
        @(negedge clk) begin src_set = 6'b000001; swi_req = 1'b1; boundary_strobe = 1'b1; end
        @(negedge clk) begin src_set = '0; boundary_strobe = 1'b0; end
        @(negedge clk);
        chk("R8 held src_id", src_id, 7);
        chk("R8 held vec_addr", vec_addr, 16'hFFDE);
        chk("R8 held int_req", int_req, 1'b1);
        ack_once();
        strobe_expect(1, "R3 swi next");
        chk("R4 swi stack_pc", stack_pc, 1'b1);
        ack_once();
        swi_req = 1'b0;
        strobe_expect(2, "R1 pin next");
        chk("R4 hw stack_pc", stack_pc, 1'b0);
        ack_once();
        // R9: acknowledge leaves the flag pending.
        chk("R9 flag kept", isr_status, 16'h8002);
        strobe_expect(2, "R9 retaken");
        ack_once();
        @(negedge clk) src_clr = 6'b000001;
        @(negedge clk) src_clr = '0;
        strobe_expect(7, "R10 cleared pin");
        ack_once();
        // R10: set wins over clear.
        @(negedge clk) begin src_set = 6'b000100; src_clr = 6'b000100; end
        @(negedge clk) begin src_set = '0; src_clr = '0; end
        chk("R10 set wins", isr_status[4], 1'b1);
        // R11: nothing eligible.
        @(negedge clk) src_clr = 6'h3F;
        @(negedge clk) src_clr = '0;
        strobe_expect(-1, "R11 empty strobe");
        summary();
    end

endmodule